// File: doc/BRIEF.md
# Transparent Window Matcher

This unit decides whether a 32-bit logical access lies inside one of two programmable transparent windows. Data accesses and instruction fetches each have their own pair of window registers. A window is defined by a base byte compared against address bits 31:24, a mask byte whose set bits remove address bits from that comparison, an enable bit, a privilege qualifier and a write-protect bit. When a lookup is presented, the unit picks the pair for the access class. It tries slot 0 first and slot 1 second, and registers a 2-bit result: no match, match, or write-protected match.

Software programs the four registers directly through a write port. There is also an allocation request. It claims a free slot in one pair and fills it from a base address and a size, and it only uses a slot whose enable bit is clear.

Top module: `tt_window_match`

## Requirements
- R1: Synchronous active-high reset clears all four window registers to zero, drives `result_valid` low and drives `result_code` to 00.
- R2: A register whose enable bit (bit 15) is clear never produces a match.
- R3: Address bits 31:24 are compared with register bits 31:24. Each bit set in the mask byte (register bits 23:16) is left out of the comparison.
- R4: When register bit 14 is set, privilege is ignored. When bit 14 is clear, the lookup's supervisor flag must equal register bit 13, or the register does not match.
- R5: A matching register yields code 10 if its write-protect bit (bit 2) is set and code 01 otherwise. No match yields 00, and code 11 never appears.
- R6: Data lookups use registers 0 and 1. Instruction lookups use registers 2 and 3. `reg_wr_sel` selects 0 = data slot 0, 1 = data slot 1, 2 = instruction slot 0, 3 = instruction slot 1.
- R7: Slot 0 of the chosen pair has priority. Slot 1 decides the result only when slot 0 does not match.
- R8: An allocation writes slot 1 of the chosen pair if that slot is disabled. Otherwise it writes slot 0 if slot 0 is disabled. Otherwise it changes nothing.
- R9: An allocated register holds the top byte of the base in bits 31:24 and the top byte of (base + size - 1) in bits 23:16. Bit 15 is set and every other bit is zero.
- R10: When a register write and an allocation request occur in the same cycle, the write takes effect and the allocation is dropped.
- R11: The result appears one clock after the lookup is presented. `result_valid` is high only in that cycle, and `result_code` is 00 whenever `result_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write one window register |
| reg_wr_sel | input | 2 | Register selected for the write |
| reg_wr_data | input | 32 | Value written to the register |
| alloc_req | input | 1 | Request to claim a free window slot |
| alloc_is_data | input | 1 | Allocation targets the data pair (1) or the instruction pair (0) |
| alloc_base | input | 32 | Start address of the window to allocate |
| alloc_size | input | 32 | Size in bytes of the window to allocate |
| lookup_valid | input | 1 | A lookup is presented this cycle |
| lookup_addr | input | 32 | Logical address of the access |
| lookup_super | input | 1 | Access is made at supervisor level |
| lookup_is_data | input | 1 | Access is a data access (1) or an instruction fetch (0) |
| result_valid | output | 1 | Registered result is valid |
| result_code | output | 2 | 00 no match, 01 match, 10 write-protected match |

## Verification
On every cycle, the assertions check the one-cycle result timing, that the result code is never 11 and is idle-zero, and that a pair with both enables clear cannot match. They also check that an allocation into a full pair leaves every register unchanged, and that reset clears the registers. The mask arithmetic, the privilege rule, slot priority, and which slot an allocation lands in can only be shown by the bench's scenarios. Each scenario programs specific windows and probes addresses just inside and just outside them. The same applies to the exact field layout of an allocated window and to a write winning over an allocation in the same cycle.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned TAG_W       = 8;
  localparam int unsigned BASE_LO     = 24;
  localparam int unsigned MASK_LO     = 16;
  localparam int unsigned EN_BIT      = 15;
  localparam int unsigned PRIV_ANY    = 14;
  localparam int unsigned PRIV_SUP    = 13;
  localparam int unsigned WP_BIT      = 2;

  typedef enum logic [1:0] {
    TT_MISS   = 2'b00,
    TT_HIT    = 2'b01,
    TT_HIT_WP = 2'b10
  } tt_result_e;
endpackage

// File: rtl/tt_reg_bank.sv
module tt_reg_bank
  import tt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned N_SLOT = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [$clog2(2*N_SLOT)-1:0]    wr_sel,
  input  logic [REG_W-1:0]               wr_data,
  input  logic                           alloc_req,
  input  logic                           alloc_is_data,
  input  logic [ADDR_W-1:0]              alloc_base,
  input  logic [ADDR_W-1:0]              alloc_size,
  output logic [2*N_SLOT-1:0][REG_W-1:0] regs_q
);
  localparam int unsigned N_REG = 2 * N_SLOT;
  localparam int unsigned IDX_W = $clog2(N_REG);

  logic [ADDR_W-1:0] alloc_last;
  logic [REG_W-1:0]  alloc_word;
  logic [IDX_W-1:0]  pair_base;
  logic [IDX_W-1:0]  alloc_idx;
  logic              alloc_free;
  logic              alloc_fire;

  always_comb begin
    alloc_last = alloc_base + alloc_size - {{(ADDR_W-1){1'b0}}, 1'b1};
    alloc_word = '0;
    alloc_word[BASE_LO +: TAG_W] = alloc_base[ADDR_W-1 -: TAG_W];
    alloc_word[MASK_LO +: TAG_W] = alloc_last[ADDR_W-1 -: TAG_W];
    alloc_word[EN_BIT]           = 1'b1;
  end

  // Slot search: highest slot of the pair first, downward.
  always_comb begin
    pair_base  = alloc_is_data ? IDX_W'(0) : IDX_W'(N_SLOT);
    alloc_idx  = pair_base;
    alloc_free = 1'b0;
    for (int s = 0; s < N_SLOT; s++) begin
      if (!alloc_free && !regs_q[pair_base + IDX_W'(N_SLOT-1-s)][EN_BIT]) begin
        alloc_free = 1'b1;
        alloc_idx  = pair_base + IDX_W'(N_SLOT-1-s);
      end
    end
  end

  assign alloc_fire = alloc_req && alloc_free && !wr_en;

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (wr_en && wr_sel == IDX_W'(g)) begin
        regs_q[g] <= wr_data;
      end else if (alloc_fire && alloc_idx == IDX_W'(g)) begin
        regs_q[g] <= alloc_word;
      end
    end
  end
endmodule

// File: rtl/tt_window_cmp.sv
module tt_window_cmp
  import tt_pkg::*;
(
  input  logic [REG_W-1:0] win_reg,
  input  logic [TAG_W-1:0] addr_tag,
  input  logic             is_super,
  output tt_result_e       res
);
  logic [TAG_W-1:0] diff;
  logic             priv_ok;
  logic             hit;

  always_comb begin
    diff    = (addr_tag ^ win_reg[BASE_LO +: TAG_W]) & ~win_reg[MASK_LO +: TAG_W];
    priv_ok = win_reg[PRIV_ANY] || (is_super == win_reg[PRIV_SUP]);
    hit     = win_reg[EN_BIT] && (diff == '0) && priv_ok;
    if (!hit)                res = TT_MISS;
    else if (win_reg[WP_BIT]) res = TT_HIT_WP;
    else                     res = TT_HIT;
  end
endmodule

// File: rtl/tt_prio_sel.sv
module tt_prio_sel
  import tt_pkg::*;
#(
  parameter int unsigned N_IN = 2
) (
  input  tt_result_e [N_IN-1:0] cand,
  output tt_result_e            res
);
  always_comb begin
    res = TT_MISS;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (cand[i] != TT_MISS) res = cand[i];
    end
  end
endmodule

// File: rtl/tt_window_match.sv
module tt_window_match
  import tt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned N_SLOT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_wr_sel,
  input  logic [31:0]       reg_wr_data,
  input  logic              alloc_req,
  input  logic              alloc_is_data,
  input  logic [ADDR_W-1:0] alloc_base,
  input  logic [ADDR_W-1:0] alloc_size,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  input  logic              lookup_super,
  input  logic              lookup_is_data,
  output logic              result_valid,
  output logic [1:0]        result_code
);
  localparam int unsigned N_REG = 2 * N_SLOT;

  logic [N_REG-1:0][REG_W-1:0]  regs_q;
  logic [N_SLOT-1:0][REG_W-1:0] slot_reg;
  tt_result_e [N_SLOT-1:0]      slot_res;
  tt_result_e                   pick_res;
  logic [TAG_W-1:0]             addr_tag;

  assign addr_tag = lookup_addr[ADDR_W-1 -: TAG_W];

  tt_reg_bank #(.ADDR_W(ADDR_W), .N_SLOT(N_SLOT)) u_bank (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (reg_wr_en),
    .wr_sel        (reg_wr_sel),
    .wr_data       (reg_wr_data),
    .alloc_req     (alloc_req),
    .alloc_is_data (alloc_is_data),
    .alloc_base    (alloc_base),
    .alloc_size    (alloc_size),
    .regs_q        (regs_q)
  );

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    assign slot_reg[s] = lookup_is_data ? regs_q[s] : regs_q[N_SLOT + s];
    tt_window_cmp u_cmp (
      .win_reg  (slot_reg[s]),
      .addr_tag (addr_tag),
      .is_super (lookup_super),
      .res      (slot_res[s])
    );
  end

  tt_prio_sel #(.N_IN(N_SLOT)) u_prio (
    .cand (slot_res),
    .res  (pick_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_valid <= 1'b0;
      result_code  <= TT_MISS;
    end else begin
      result_valid <= lookup_valid;
      result_code  <= lookup_valid ? pick_res : TT_MISS;
    end
  end
endmodule

// File: rtl/tt_window_match_chk.sv
module tt_window_match_chk (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic              alloc_req,
  input logic              alloc_is_data,
  input logic              lookup_valid,
  input logic              lookup_is_data,
  input logic              result_valid,
  input logic [1:0]        result_code,
  input logic [3:0][31:0]  bank_q
);
  logic look_pair_off;
  logic alloc_pair_full;

  assign look_pair_off   = lookup_is_data ? !(bank_q[0][15] || bank_q[1][15])
                                          : !(bank_q[2][15] || bank_q[3][15]);
  assign alloc_pair_full = alloc_is_data ? (bank_q[0][15] && bank_q[1][15])
                                         : (bank_q[2][15] && bank_q[3][15]);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (bank_q == '0 && !result_valid && result_code == 2'b00));

  assert_pair_off_miss_R2: assert property (@(posedge clk) disable iff (rst)
    (lookup_valid && look_pair_off) |=> result_code == 2'b00);

  assert_code_legal_R5: assert property (@(posedge clk) disable iff (rst)
    result_code != 2'b11);

  assert_full_alloc_noop_R8: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && !reg_wr_en && alloc_pair_full) |=> $stable(bank_q));

  assert_valid_latency_R11: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> result_valid);

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> result_code == 2'b00);
endmodule

bind tt_window_match tt_window_match_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .reg_wr_en      (reg_wr_en),
  .alloc_req      (alloc_req),
  .alloc_is_data  (alloc_is_data),
  .lookup_valid   (lookup_valid),
  .lookup_is_data (lookup_is_data),
  .result_valid   (result_valid),
  .result_code    (result_code),
  .bank_q         (regs_q)
);

// File: tb/test_tt_window_match.sv
module test_tt_window_match;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr_en;
  logic [1:0]  reg_wr_sel;
  logic [31:0] reg_wr_data;
  logic        alloc_req;
  logic        alloc_is_data;
  logic [31:0] alloc_base;
  logic [31:0] alloc_size;
  logic        lookup_valid;
  logic [31:0] lookup_addr;
  logic        lookup_super;
  logic        lookup_is_data;
  logic        result_valid;
  logic [1:0]  result_code;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tt_window_match i_tt_window_match (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .alloc_req(alloc_req), .alloc_is_data(alloc_is_data),
    .alloc_base(alloc_base), .alloc_size(alloc_size),
    .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
    .lookup_super(lookup_super), .lookup_is_data(lookup_is_data),
    .result_valid(result_valid), .result_code(result_code)
  );

  function automatic logic [31:0] mk(input logic [7:0] base, input logic [7:0] mask,
                                     input bit en, input bit any, input bit sup, input bit wp);
    logic [31:0] v = '0;
    v[31:24] = base; v[23:16] = mask;
    v[15] = en; v[14] = any; v[13] = sup; v[2] = wp;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; reg_wr_en = 0; alloc_req = 0; lookup_valid = 0;
    reg_wr_sel = 0; reg_wr_data = 0; alloc_is_data = 0; alloc_base = 0; alloc_size = 0;
    lookup_addr = 0; lookup_super = 0; lookup_is_data = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = val;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic alloc(input bit is_data, input logic [31:0] base, input logic [31:0] size);
    @(negedge clk);
    alloc_req = 1; alloc_is_data = is_data; alloc_base = base; alloc_size = size;
    @(negedge clk);
    alloc_req = 0;
  endtask

  task automatic look(input string req, input logic [31:0] addr, input bit sup,
                      input bit is_data, input logic [1:0] exp);
    @(negedge clk);
    lookup_valid = 1; lookup_addr = addr; lookup_super = sup; lookup_is_data = is_data;
    @(negedge clk);
    lookup_valid = 0;
    check({req, " valid"}, 32'(result_valid), 32'd1);
    check(req, 32'(result_code), 32'(exp));
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 valid after reset", 32'(result_valid), 32'd0);
    check("R1 code after reset", 32'(result_code), 32'd0);
    look("R1 R2 cleared regs miss", 32'h0000_0000, 1'b0, 1'b1, 2'b00);
    @(negedge clk);
    check("R11 idle valid", 32'(result_valid), 32'd0);
    check("R11 idle code", 32'(result_code), 32'd0);
  endtask

  task automatic t_disabled();
    do_reset();
    wr(2'd0, mk(8'h40, 8'h00, 0, 1, 0, 0));
    look("R2 disabled miss", 32'h4012_3456, 1'b1, 1'b1, 2'b00);
  endtask

  task automatic t_mask();
    do_reset();
    wr(2'd0, mk(8'h40, 8'h0F, 1, 1, 0, 0));
    look("R3 masked hit", 32'h4A00_0000, 1'b0, 1'b1, 2'b01);
    look("R3 top nibble miss", 32'h5A00_0000, 1'b0, 1'b1, 2'b00);
    look("R3 all masked ones", 32'h4FFF_FFFF, 1'b1, 1'b1, 2'b01);
  endtask

  task automatic t_priv();
    do_reset();
    wr(2'd0, mk(8'h80, 8'h00, 1, 0, 1, 0));
    look("R4 super only super", 32'h8000_0010, 1'b1, 1'b1, 2'b01);
    look("R4 super only user", 32'h8000_0010, 1'b0, 1'b1, 2'b00);
    wr(2'd0, mk(8'h80, 8'h00, 1, 0, 0, 0));
    look("R4 user only user", 32'h80FF_0000, 1'b0, 1'b1, 2'b01);
    look("R4 user only super", 32'h80FF_0000, 1'b1, 1'b1, 2'b00);
    wr(2'd0, mk(8'h80, 8'h00, 1, 1, 0, 0));
    look("R4 any super", 32'h8000_0000, 1'b1, 1'b1, 2'b01);
    look("R4 any user", 32'h8000_0000, 1'b0, 1'b1, 2'b01);
  endtask

  task automatic t_wp();
    do_reset();
    wr(2'd1, mk(8'hC0, 8'h00, 1, 1, 0, 1));
    look("R5 write protected", 32'hC000_1234, 1'b0, 1'b1, 2'b10);
  endtask

  task automatic t_pair();
    do_reset();
    wr(2'd0, mk(8'h22, 8'h00, 1, 1, 0, 0));
    look("R6 data reg vs inst lookup", 32'h2200_0000, 1'b0, 1'b0, 2'b00);
    wr(2'd0, 32'h0);
    wr(2'd3, mk(8'h22, 8'h00, 1, 1, 0, 1));
    look("R6 inst slot1 inst lookup", 32'h2200_0000, 1'b0, 1'b0, 2'b10);
    look("R6 inst slot1 data lookup", 32'h2200_0000, 1'b0, 1'b1, 2'b00);
    wr(2'd2, mk(8'h22, 8'h00, 1, 1, 0, 0));
    look("R7 inst slot0 first", 32'h2200_0000, 1'b1, 1'b0, 2'b01);
  endtask

  task automatic t_prio();
    do_reset();
    wr(2'd0, mk(8'h33, 8'h00, 1, 1, 0, 0));
    wr(2'd1, mk(8'h33, 8'h00, 1, 1, 0, 1));
    look("R7 slot0 wins", 32'h3300_0000, 1'b0, 1'b1, 2'b01);
    wr(2'd0, mk(8'h33, 8'h00, 1, 0, 1, 0));
    look("R7 slot0 priv miss falls to slot1", 32'h3300_0000, 1'b0, 1'b1, 2'b10);
    wr(2'd0, mk(8'h33, 8'h00, 0, 1, 0, 0));
    look("R7 slot0 off falls to slot1", 32'h3300_0000, 1'b1, 1'b1, 2'b10);
  endtask

  task automatic t_alloc();
    do_reset();
    alloc(1'b1, 32'h3000_0000, 32'h0100_0000);
    alloc(1'b1, 32'h6000_0000, 32'h0000_0100);
    alloc(1'b1, 32'h9000_0000, 32'h0000_1000);
    look("R8 full pair no alloc", 32'h9000_0000, 1'b0, 1'b1, 2'b00);
    look("R9 first window hit", 32'h3080_0000, 1'b0, 1'b1, 2'b01);
    look("R9 end byte as mask", 32'h0000_0000, 1'b0, 1'b1, 2'b01);
    look("R9 unmasked bit miss", 32'h3100_0000, 1'b0, 1'b1, 2'b00);
    look("R9 priv field zero super miss", 32'h3000_0000, 1'b1, 1'b1, 2'b00);
    look("R8 second window hit", 32'h6000_0000, 1'b0, 1'b1, 2'b01);
    look("R8 inst pair untouched", 32'h3000_0000, 1'b0, 1'b0, 2'b00);
    wr(2'd1, 32'h0);
    look("R8 first alloc went to slot1", 32'h3000_0000, 1'b0, 1'b1, 2'b00);
    look("R8 second alloc in slot0", 32'h6000_0000, 1'b0, 1'b1, 2'b01);
  endtask

  task automatic t_conflict();
    do_reset();
    @(negedge clk);
    reg_wr_en = 1; reg_wr_sel = 2'd0; reg_wr_data = mk(8'h70, 8'h00, 1, 1, 0, 0);
    alloc_req = 1; alloc_is_data = 1; alloc_base = 32'h5000_0000; alloc_size = 32'h10;
    @(negedge clk);
    reg_wr_en = 0; alloc_req = 0;
    look("R10 write applied", 32'h7000_0000, 1'b0, 1'b1, 2'b01);
    look("R10 alloc dropped", 32'h5000_0000, 1'b0, 1'b1, 2'b00);
  endtask

  initial begin
    rst = 1'b1;
    t_reset();
    t_disabled();
    t_mask();
    t_priv();
    t_wp();
    t_pair();
    t_prio();
    t_alloc();
    t_conflict();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule